// File: doc/BRIEF.md
# Power-Down Entry and Wake Controller

This block decides whether a power-down instruction actually puts the device into power-down, and when power-down ends. The CPU raises a one-cycle strobe while the instruction executes. A single mode input picks one of two policies. In NMI-gated mode, power-down starts only while the synchronised NMI pin is low, and only an external reset ends it. In interrupt-gated mode, power-down starts only while every enabled fast interrupt pin is at its inactive level, and any enabled pin turning active ends it.

The NMI pin and the interrupt pins each pass through a two-flop synchroniser before they are used. The enable mask and the active-level setting are static configuration and are used directly. The mode is captured when power-down starts, so a change to the mode input during power-down has no effect until the next entry. An external reset input returns the controller to the run state from any state. The clock-gating cells that `pd_active_o` drives are outside this block.

Top module: `pdc_ctrl`

## Requirements
- R1: After the asynchronous reset `rst_ni`, `pd_active_o` and `wake_o` are both 0.
- R2: `pd_active_o` rises only on the clock edge after an edge at which `pd_instr_i` was 1. With no strobe, the pin levels have no effect.
- R3: With `cfg_irq_mode_i`=0, a strobe while the synchronised `nmi_i` is 0 sets `pd_active_o` at that edge. A strobe while `nmi_i` is 1 has no effect.
- R4: After an entry with `cfg_irq_mode_i`=0, interrupt pins never end power-down and `wake_o` stays 0.
- R5: With `cfg_irq_mode_i`=1, a strobe enters power-down only if no enabled pin is active. Pin i is active when it is high and `irq_act_high_i[i]`=1, or when it is low and `irq_act_high_i[i]`=0.
- R6: After an entry with `cfg_irq_mode_i`=1, an enabled active pin clears `pd_active_o` and sets `wake_o` at the same edge. `wake_o` lasts exactly one cycle.
- R7: Pins with `irq_en_i[i]`=0 are ignored for both the entry check and the wake check.
- R8: `ext_rst_i`=1 at an edge clears `pd_active_o` and does not raise `wake_o`. It takes priority over a strobe at the same edge.
- R9: A level sampled on `nmi_i` or `irq_i` at edge n is first used for a decision at edge n+2.
- R10: The mode in force during power-down is the value of `cfg_irq_mode_i` at the entry edge. Later changes to the input do not change the wake sources.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pd_instr_i | input | 1 | One-cycle strobe: power-down instruction executing |
| cfg_irq_mode_i | input | 1 | 0 = NMI-gated mode, 1 = interrupt-gated mode |
| nmi_i | input | 1 | NMI pin level (asynchronous) |
| irq_i | input | N_IRQ | Fast external interrupt pin levels (asynchronous) |
| irq_en_i | input | N_IRQ | Per-pin enable |
| irq_act_high_i | input | N_IRQ | Per-pin active level, 1 = active high |
| ext_rst_i | input | 1 | External reset pin, active high |
| pd_active_o | output | 1 | Power-down in force |
| wake_o | output | 1 | One-cycle wake pulse on interrupt exit |

## Verification
The hardest case to reach from the ports is a strobe that arrives while a pin change is still inside the synchronisers. The stimulus handles this by moving the NMI pin in the same cycle as the first of three back-to-back strobes. Only the third strobe may enter power-down. A second hard case is a mode change during power-down. The bench enters power-down under one mode, flips the mode input, and then drives the pin that only the other mode would accept as a wake source. A cycle-by-cycle reference model with a two-deep history queue follows every cycle.

// File: rtl/pdc_pkg.sv
package pdc_pkg;
  typedef enum logic {
    PDC_RUN  = 1'b0,
    PDC_DOWN = 1'b1
  } pdc_state_e;

  typedef enum logic {
    PDC_MODE_NMI = 1'b0,
    PDC_MODE_IRQ = 1'b1
  } pdc_mode_e;
endpackage

// File: rtl/pdc_sync.sv
module pdc_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/pdc_irq_qual.sv
module pdc_irq_qual #(
  parameter int N_IRQ = 4
) (
  input  logic [N_IRQ-1:0] irq_s_i,
  input  logic [N_IRQ-1:0] irq_en_i,
  input  logic [N_IRQ-1:0] irq_act_high_i,
  output logic             any_act_o
);
  logic [N_IRQ-1:0] pin_act;

  for (genvar i = 0; i < N_IRQ; i++) begin : g_pin
    assign pin_act[i] = irq_en_i[i] &
                        (irq_act_high_i[i] ? irq_s_i[i] : ~irq_s_i[i]);
  end

  assign any_act_o = |pin_act;
endmodule

// File: rtl/pdc_fsm.sv
module pdc_fsm
  import pdc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pd_instr_i,
  input  logic cfg_irq_mode_i,
  input  logic nmi_s_i,
  input  logic irq_any_act_i,
  input  logic ext_rst_i,
  output logic pd_active_o,
  output logic wake_o
);
  pdc_state_e state_q, state_d;
  pdc_mode_e  mode_q, mode_d;
  logic       wake_q, wake_d;
  logic       entry_ok;

  // entry condition depends on the live mode input
  always_comb begin
    if (pdc_mode_e'(cfg_irq_mode_i) == PDC_MODE_NMI) entry_ok = ~nmi_s_i;
    else                                              entry_ok = ~irq_any_act_i;
  end

  always_comb begin
    state_d = state_q;
    mode_d  = mode_q;
    wake_d  = 1'b0;
    if (ext_rst_i) begin
      state_d = PDC_RUN;
    end else begin
      unique case (state_q)
        PDC_RUN: if (pd_instr_i && entry_ok) begin
          state_d = PDC_DOWN;
          mode_d  = pdc_mode_e'(cfg_irq_mode_i);
        end
        PDC_DOWN: if (mode_q == PDC_MODE_IRQ && irq_any_act_i) begin
          state_d = PDC_RUN;
          wake_d  = 1'b1;
        end
        default: state_d = PDC_RUN;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PDC_RUN;
      mode_q  <= PDC_MODE_NMI;
      wake_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      mode_q  <= mode_d;
      wake_q  <= wake_d;
    end
  end

  assign pd_active_o = (state_q == PDC_DOWN);
  assign wake_o      = wake_q;

  AST_ENTRY_NEEDS_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pd_active_o) |-> $past(pd_instr_i)); // R2
  AST_NMI_BLOCKS_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pd_active_o && pd_instr_i && !cfg_irq_mode_i && nmi_s_i) |=> !pd_active_o); // R3
  AST_NMI_MODE_NO_WAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pd_active_o && mode_q == PDC_MODE_NMI) |=> !wake_o); // R4
  AST_IRQ_BLOCKS_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pd_active_o && pd_instr_i && cfg_irq_mode_i && irq_any_act_i) |=> !pd_active_o); // R5
  AST_WAKE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |=> !wake_o); // R6
  AST_WAKE_LEAVES_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> (!pd_active_o && $past(pd_active_o))); // R6
  AST_EXT_RST_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_rst_i |=> (!pd_active_o && !wake_o)); // R8
endmodule

// File: rtl/pdc_ctrl.sv
module pdc_ctrl #(
  parameter int N_IRQ       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pd_instr_i,
  input  logic             cfg_irq_mode_i,
  input  logic             nmi_i,
  input  logic [N_IRQ-1:0] irq_i,
  input  logic [N_IRQ-1:0] irq_en_i,
  input  logic [N_IRQ-1:0] irq_act_high_i,
  input  logic             ext_rst_i,
  output logic             pd_active_o,
  output logic             wake_o
);
  localparam int SyncW = N_IRQ + 1;

  logic [SyncW-1:0] pins_s;
  logic             irq_any_act;

  pdc_sync #(.WIDTH(SyncW), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({nmi_i, irq_i}),
    .q_o    (pins_s)
  );

  pdc_irq_qual #(.N_IRQ(N_IRQ)) i_qual (
    .irq_s_i        (pins_s[N_IRQ-1:0]),
    .irq_en_i       (irq_en_i),
    .irq_act_high_i (irq_act_high_i),
    .any_act_o      (irq_any_act)
  );

  pdc_fsm i_fsm (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .pd_instr_i     (pd_instr_i),
    .cfg_irq_mode_i (cfg_irq_mode_i),
    .nmi_s_i        (pins_s[N_IRQ]),
    .irq_any_act_i  (irq_any_act),
    .ext_rst_i      (ext_rst_i),
    .pd_active_o    (pd_active_o),
    .wake_o         (wake_o)
  );

  // R1: outputs low out of reset
  AST_RESET_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (!pd_active_o && !wake_o)); // R1
endmodule

// File: tb/test_pdc_ctrl.sv
module test_pdc_ctrl;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         pd_instr = 1'b0, cfg = 1'b0, nmi = 1'b1, ext_rst = 1'b0;
  logic [N-1:0] irq = '0, en = '0, acth = '0;
  logic         pd_active, wake;

  int checks = 0, errors = 0, cyc = 0;

  pdc_ctrl #(.N_IRQ(N)) i_pdc_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .pd_instr_i(pd_instr), .cfg_irq_mode_i(cfg),
    .nmi_i(nmi), .irq_i(irq), .irq_en_i(en), .irq_act_high_i(acth),
    .ext_rst_i(ext_rst), .pd_active_o(pd_active), .wake_o(wake)
  );

  always #10 clk = ~clk; // 50 MHz

  // reference model: history queue stands in for the two synchroniser stages
  logic [N:0] hist[$];
  bit         m_pd, m_wake, m_mode;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pd = 0; m_wake = 0; m_mode = 0;
      hist.delete(); hist.push_back('0); hist.push_back('0);
    end else begin
      logic [N:0]   old;
      logic [N-1:0] act;
      old    = hist.pop_front();
      act    = ~(old[N-1:0] ^ acth) & en;
      m_wake = 0;
      if (ext_rst) m_pd = 0;
      else if (!m_pd) begin
        if (pd_instr && (cfg ? (act == 0) : !old[N])) begin
          m_pd = 1; m_mode = cfg;
        end
      end else if (m_mode && act != 0) begin
        m_pd = 0; m_wake = 1;
      end
      hist.push_back({nmi, irq});
    end
  end

  task automatic check(input bit ok, input string req, input int act_v, input int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", req, act_v, exp_v, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    check(pd_active == m_pd, "R3/R5/R6/R8 model pd_active", pd_active, m_pd);
    check(wake == m_wake, "R6 model wake", wake, m_wake);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic strobe();
    pd_instr = 1; @(negedge clk); pd_instr = 0;
  endtask

  task automatic xrst();
    ext_rst = 1; @(negedge clk); ext_rst = 0;
    check(pd_active == 0 && wake == 0, "R8 ext reset clears", pd_active, 0);
  endtask

  initial begin
    step(2);
    check(pd_active == 0 && wake == 0, "R1 in reset", pd_active, 0);
    rst_n = 1;
    step(3);
    check(pd_active == 0 && wake == 0, "R1 after reset", pd_active, 0);

    // R2: pin activity without strobe
    nmi = 0; irq = 4'b1010; step(3); irq = 4'b0101; step(3);
    check(pd_active == 0, "R2 no strobe no entry", pd_active, 0);

    // R3: NMI-gated entry
    cfg = 0; nmi = 1; step(3); strobe();
    check(pd_active == 0, "R3 nmi high blocks", pd_active, 0);
    nmi = 0; step(3); strobe();
    check(pd_active == 1, "R3 nmi low enters", pd_active, 1);
    // R4: enabled active pins do not wake in NMI mode
    en = 4'b1111; acth = 4'b1111; irq = 4'b1111; step(5);
    check(pd_active == 1 && wake == 0, "R4 no irq wake in nmi mode", pd_active, 1);
    xrst();
    irq = 4'b0000; en = 4'b0000;

    // R9: synchroniser latency on nmi
    nmi = 1; step(3);
    nmi = 0; strobe();
    check(pd_active == 0, "R9 edge n sees old nmi", pd_active, 0);
    strobe();
    check(pd_active == 0, "R9 edge n+1 sees old nmi", pd_active, 0);
    strobe();
    check(pd_active == 1, "R9 edge n+2 sees new nmi", pd_active, 1);
    xrst();

    // R5/R7: interrupt-gated entry; pin0 active high, pin1 active low, pins 2/3 disabled
    cfg = 1; nmi = 1; en = 4'b0011; acth = 4'b0001; irq = 4'b0110; step(3);
    strobe();
    check(pd_active == 1, "R5 all enabled inactive enters (nmi ignored)", pd_active, 1);
    irq = 4'b1010; step(4);
    check(pd_active == 1 && wake == 0, "R7 disabled pins do not wake", pd_active, 1);
    irq = 4'b0000; // pin1 low -> active
    step(1); check(pd_active == 1, "R9 wake not yet (n)", pd_active, 1);
    step(1); check(pd_active == 1, "R9 wake not yet (n+1)", pd_active, 1);
    step(1); check(pd_active == 0 && wake == 1, "R6 wake at n+2", wake, 1);
    step(1); check(wake == 0, "R6 wake one cycle", wake, 0);

    // R5: entry blocked by active pins
    strobe();
    check(pd_active == 0, "R5 active low pin blocks", pd_active, 0);
    irq = 4'b0011; step(3); strobe();
    check(pd_active == 0, "R5 active high pin blocks", pd_active, 0);
    irq = 4'b1110; step(3); strobe();
    check(pd_active == 1, "R7 disabled active-looking pins ignored at entry", pd_active, 1);

    // R10: mode latched at entry (IRQ mode, input flipped to 0)
    cfg = 0; irq = 4'b1111; step(3);
    check(pd_active == 0, "R10 irq wake kept after mode flip", pd_active, 0);
    // R10: NMI-mode entry, input flipped to 1, pin activity must not wake
    nmi = 0; irq = 4'b0010; step(3); strobe();
    check(pd_active == 1, "R3 enter nmi mode", pd_active, 1);
    cfg = 1; irq = 4'b0001; step(5);
    check(pd_active == 1 && wake == 0, "R10 nmi mode kept after mode flip", pd_active, 1);
    xrst();

    // R8: ext reset beats strobe
    cfg = 0; nmi = 0; step(3);
    ext_rst = 1; pd_instr = 1; step(1); ext_rst = 0; pd_instr = 0;
    check(pd_active == 0, "R8 ext reset priority over strobe", pd_active, 0);

    // R1: chip reset during power-down
    strobe();
    check(pd_active == 1, "R3 enter before chip reset", pd_active, 1);
    rst_n = 0; #1;
    check(pd_active == 0 && wake == 0, "R1 async reset clears", pd_active, 0);
    step(2); rst_n = 1; step(3);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule